// File: doc/BRIEF.md
# Bi-endian Load/Store Lane Steering Unit

This unit sits between the load/store port of a 32-bit processor and a bus whose data path is one word wide. Each access carries a size (byte, halfword or word), the byte offset inside the addressed word, a direction and, for loads, a signed flag. The unit chooses which byte lanes the access touches under a single endian-mode bit. For a store it spreads the write data across the lanes and raises the byte enables. For a load it takes the word read from the bus, picks out the addressed byte or halfword, moves it to the bottom of the result and extends it with zeros or with its sign.

Word accesses pass through unchanged in either mode. Only the lane chosen for a sub-word access depends on the mode. Data written as words in one mode and read back as bytes in the other therefore shows the lane order of the mode in force at read time. The mode bit is held in a register that is written through a load strobe and clears on reset. Every response is registered and appears one cycle after its request. An access whose offset does not suit its size is flagged and touches no lane.

Top module: `endian_lane_steer`

## Requirements
- R1: A word access (size code 2) at offset 0 returns `mem_rdata` unchanged on loads, drives `req_wdata` unchanged on stores, and enables all four lanes (`rsp_be` = 4'b1111), in both modes.
- R2: With `big_endian` = 0, a byte access at offset k uses lane k: bits 8k+7:8k, `rsp_be` bit k.
- R3: With `big_endian` = 1, a byte access at offset k uses lane 3-k.
- R4: A halfword access (size code 1) at offset 0 uses lanes 1:0 in little-endian mode and lanes 3:2 in big-endian mode. Offset 2 uses the other pair. The lower-numbered lane of the pair always supplies bits 7:0 of the halfword, so no bytes are swapped inside a halfword.
- R5: A load result is right-justified. With `req_signed` = 1, a byte or halfword is sign-extended from its bit 7 or bit 15. With `req_signed` = 0 it is zero-extended.
- R6: Store data is copied onto every lane: a byte four times, a halfword twice. `rsp_be` has one bit set for a byte store and two adjacent bits set for a halfword store.
- R7: The access is misaligned in three cases: a halfword with offset bit 0 set, a word with a non-zero offset, or the reserved size code 3. A misaligned access sets `rsp_misalign` and forces `rsp_be`, `rsp_wdata` and `rsp_rdata` to zero.
- R8: Reset is synchronous and active high. It clears the mode bit to little-endian and all response outputs to zero.
- R9: A mode write (`mode_load`) takes effect at the clock edge. An access presented in the same cycle still uses the old mode, and the next access uses the new one.
- R10: `rsp_valid` follows `req_valid` one cycle later. `rsp_rdata` is zero for stores, and `rsp_wdata` is zero for loads. All response fields are zero when `rsp_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_load | input | 1 | Writes `mode_din` into the mode register |
| mode_din | input | 1 | New mode value: 1 = big-endian |
| big_endian | output | 1 | Current mode register value |
| req_valid | input | 1 | An access is presented this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 reserved |
| req_signed | input | 1 | Sign-extend a loaded byte or halfword |
| req_byte_off | input | 2 | Byte offset inside the word (address bits 1:0) |
| req_wdata | input | 32 | Store data, right-justified |
| mem_rdata | input | 32 | Word read from the bus for this load |
| rsp_valid | output | 1 | Registered response valid |
| rsp_be | output | 4 | Lane enables, bit k = bits 8k+7:8k |
| rsp_wdata | output | 32 | Store data placed on the lanes |
| rsp_rdata | output | 32 | Extracted and extended load result |
| rsp_misalign | output | 1 | Alignment error for this access |

## Verification
The bench reads the word 0xBBCCDDEE at every byte and halfword offset in both modes. A design that left the lane mapping fixed, or that swapped the two bytes inside a halfword, would return wrong bytes such as 0xDD in place of 0xCC. Signed loads use values whose top bit is set, so a design that zero-extended them, or extended from the wrong bit, would miss the 0xFFFF prefix. A mode write is issued in the same cycle as a load, so a design that applied the new mode at once would return 0xBB where 0xEE is due. Misaligned halfword and word accesses and the reserved size are also presented, so a design that still raised byte enables or leaked data on them would be caught.

// File: rtl/lane_pkg.sv
package lane_pkg;
  typedef enum logic [1:0] {
    ACC_BYTE = 2'd0,
    ACC_HALF = 2'd1,
    ACC_WORD = 2'd2,
    ACC_RSVD = 2'd3
  } acc_size_e;
endpackage

// File: rtl/lane_align_check.sv
module lane_align_check
  import lane_pkg::*;
#(
  parameter int OFF_W = 2
) (
  input  acc_size_e        size,
  input  logic [OFF_W-1:0] off,
  output logic             bad
);
  always_comb begin
    case (size)
      ACC_BYTE: bad = 1'b0;
      ACC_HALF: bad = off[0];
      ACC_WORD: bad = |off;
      default:  bad = 1'b1;
    endcase
  end
endmodule

// File: rtl/lane_index_map.sv
module lane_index_map
  import lane_pkg::*;
#(
  parameter int LANES = 4,
  parameter int OFF_W = 2
) (
  input  acc_size_e        size,
  input  logic [OFF_W-1:0] off,
  input  logic             big,
  output logic [OFF_W-1:0] base,
  output logic [LANES-1:0] mask
);
  localparam logic [OFF_W-1:0] TOP_LANE  = OFF_W'(LANES - 1);
  localparam logic [OFF_W-1:0] PAIR_LANE = OFF_W'(LANES - 2);

  // lowest lane of the access
  always_comb begin
    case (size)
      ACC_BYTE: base = big ? (TOP_LANE - off) : off;
      ACC_HALF: base = big ? (PAIR_LANE - off) : off;
      default:  base = '0;
    endcase
  end

  genvar i;
  generate
    for (i = 0; i < LANES; i++) begin : g_lane
      logic single_hit;
      logic pair_hit;
      assign single_hit = (base == OFF_W'(i));
      if (i == 0) begin : g_first
        assign pair_hit = single_hit;
      end else begin : g_rest
        assign pair_hit = single_hit || (base == OFF_W'(i - 1));
      end
      always_comb begin
        case (size)
          ACC_BYTE: mask[i] = single_hit;
          ACC_HALF: mask[i] = pair_hit;
          ACC_WORD: mask[i] = 1'b1;
          default:  mask[i] = 1'b0;
        endcase
      end
    end
  endgenerate
endmodule

// File: rtl/lane_store_pack.sv
module lane_store_pack
  import lane_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LANES  = DATA_W / 8
) (
  input  acc_size_e         size,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] lane_data
);
  localparam int HALVES = LANES / 2;

  always_comb begin
    case (size)
      ACC_BYTE: lane_data = {LANES{wdata[7:0]}};
      ACC_HALF: lane_data = {HALVES{wdata[15:0]}};
      default:  lane_data = wdata;
    endcase
  end
endmodule

// File: rtl/lane_load_extract.sv
module lane_load_extract
  import lane_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LANES  = DATA_W / 8,
  parameter int OFF_W  = 2
) (
  input  acc_size_e         size,
  input  logic [OFF_W-1:0]  base,
  input  logic              sgn,
  input  logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] result
);
  logic [7:0]  lane_b [LANES];
  logic [7:0]  byte_v;
  logic [15:0] half_v;

  genvar g;
  generate
    for (g = 0; g < LANES; g++) begin : g_split
      assign lane_b[g] = rdata[8*g +: 8];
    end
  endgenerate

  // the upper lane of the pair holds the upper half of the halfword
  assign byte_v = lane_b[base];
  assign half_v = {lane_b[base + OFF_W'(1)], lane_b[base]};

  always_comb begin
    case (size)
      ACC_BYTE: result = {{(DATA_W-8){sgn & byte_v[7]}}, byte_v};
      ACC_HALF: result = {{(DATA_W-16){sgn & half_v[15]}}, half_v};
      default:  result = rdata;
    endcase
  end
endmodule

// File: rtl/endian_lane_steer.sv
module endian_lane_steer
  import lane_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8,
  localparam int OFF_W = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_load,
  input  logic              mode_din,
  output logic              big_endian,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic              req_signed,
  input  logic [OFF_W-1:0]  req_byte_off,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              rsp_valid,
  output logic [LANES-1:0]  rsp_be,
  output logic [DATA_W-1:0] rsp_wdata,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_misalign
);
  acc_size_e         sz;
  logic              mis;
  logic [OFF_W-1:0]  base;
  logic [LANES-1:0]  mask;
  logic [DATA_W-1:0] packed_w;
  logic [DATA_W-1:0] loaded;
  logic              mode_q;

  assign sz = acc_size_e'(req_size);

  lane_align_check #(.OFF_W(OFF_W)) u_align (
    .size(sz), .off(req_byte_off), .bad(mis)
  );

  lane_index_map #(.LANES(LANES), .OFF_W(OFF_W)) u_map (
    .size(sz), .off(req_byte_off), .big(mode_q), .base(base), .mask(mask)
  );

  lane_store_pack #(.DATA_W(DATA_W), .LANES(LANES)) u_pack (
    .size(sz), .wdata(req_wdata), .lane_data(packed_w)
  );

  lane_load_extract #(.DATA_W(DATA_W), .LANES(LANES), .OFF_W(OFF_W)) u_load (
    .size(sz), .base(base), .sgn(req_signed), .rdata(mem_rdata), .result(loaded)
  );

  // mode register: the access in the same cycle sees the old value
  always_ff @(posedge clk) begin
    if (rst)            mode_q <= 1'b0;
    else if (mode_load) mode_q <= mode_din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid    <= 1'b0;
      rsp_be       <= '0;
      rsp_wdata    <= '0;
      rsp_rdata    <= '0;
      rsp_misalign <= 1'b0;
    end else begin
      rsp_valid    <= req_valid;
      rsp_misalign <= req_valid & mis;
      rsp_be       <= (req_valid && !mis) ? mask : '0;
      rsp_wdata    <= (req_valid && !mis && req_write) ? packed_w : '0;
      rsp_rdata    <= (req_valid && !mis && !req_write) ? loaded : '0;
    end
  end

  assign big_endian = mode_q;
endmodule

// File: rtl/lane_steer_chk.sv
module lane_steer_chk #(
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8,
  localparam int OFF_W = $clog2(LANES)
) (
  input logic              clk,
  input logic              rst,
  input logic              big_endian,
  input logic              req_valid,
  input logic              req_write,
  input logic [1:0]        req_size,
  input logic [OFF_W-1:0]  req_byte_off,
  input logic [DATA_W-1:0] mem_rdata,
  input logic              rsp_valid,
  input logic [LANES-1:0]  rsp_be,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic              rsp_misalign
);
  // R1
  word_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write && req_size == 2'd2 && req_byte_off == '0)
      |=> (rsp_rdata == $past(mem_rdata) && rsp_be == {LANES{1'b1}}));

  // R6
  byte_one_lane_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_size == 2'd0) |=> ($countones(rsp_be) == 1));

  // R6
  half_two_lane_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_size == 2'd1 && !req_byte_off[0]) |=> ($countones(rsp_be) == 2));

  // R7
  misalign_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_misalign |-> (rsp_be == '0 && rsp_rdata == '0));

  // R8
  reset_le_chk: assert property (@(posedge clk)
    rst |=> (big_endian == 1'b0 && rsp_valid == 1'b0));

  // R9
  old_mode_used_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write && req_size == 2'd0 && req_byte_off == '0)
      |=> (rsp_rdata[7:0] == ($past(big_endian) ? $past(mem_rdata[DATA_W-1 -: 8])
                                                 : $past(mem_rdata[7:0]))));

  // R10
  idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !rsp_valid |-> (rsp_be == '0 && !rsp_misalign));
endmodule

bind endian_lane_steer lane_steer_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .big_endian(big_endian), .req_valid(req_valid),
  .req_write(req_write), .req_size(req_size), .req_byte_off(req_byte_off),
  .mem_rdata(mem_rdata), .rsp_valid(rsp_valid), .rsp_be(rsp_be),
  .rsp_rdata(rsp_rdata), .rsp_misalign(rsp_misalign)
);

// File: tb/sim_endian_lane_steer.sv
module sim_endian_lane_steer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mode_load = 1'b0, mode_din = 1'b0;
  logic        big_endian;
  logic        req_valid = 1'b0, req_write = 1'b0, req_signed = 1'b0;
  logic [1:0]  req_size = 2'd0, req_byte_off = 2'd0;
  logic [31:0] req_wdata = '0, mem_rdata = '0;
  logic        rsp_valid, rsp_misalign;
  logic [3:0]  rsp_be;
  logic [31:0] rsp_wdata, rsp_rdata;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  bit model_big = 1'b0;

  typedef struct {
    logic [3:0]  be;
    logic [31:0] wd;
    logic [31:0] rd;
    logic        mis;
    string       tag;
  } exp_t;
  exp_t sb[$];

  always #5 clk = ~clk;

  endian_lane_steer u0 (
    .clk(clk), .rst(rst), .mode_load(mode_load), .mode_din(mode_din),
    .big_endian(big_endian), .req_valid(req_valid), .req_write(req_write),
    .req_size(req_size), .req_signed(req_signed), .req_byte_off(req_byte_off),
    .req_wdata(req_wdata), .mem_rdata(mem_rdata), .rsp_valid(rsp_valid),
    .rsp_be(rsp_be), .rsp_wdata(rsp_wdata), .rsp_rdata(rsp_rdata),
    .rsp_misalign(rsp_misalign)
  );

  function automatic exp_t model(bit wr, logic [1:0] sz, bit sg, logic [1:0] off,
                                 logic [31:0] wd, logic [31:0] rd, bit big, string tag);
    exp_t e;
    int lane;
    logic [31:0] v;
    e.tag = tag; e.be = '0; e.wd = '0; e.rd = '0;
    e.mis = (sz == 2'd3) || (sz == 2'd1 && off[0]) || (sz == 2'd2 && off != 2'd0);
    if (e.mis) return e;
    if (sz == 2'd0) begin
      lane = big ? 3 - int'(off) : int'(off);
      e.be = 4'b0001 << lane;
      v = (rd >> (8 * lane)) & 32'hFF;
      if (sg && v[7]) v = v | 32'hFFFF_FF00;
      if (wr) e.wd = {4{wd[7:0]}}; else e.rd = v;
    end else if (sz == 2'd1) begin
      lane = big ? 2 - int'(off) : int'(off);
      e.be = 4'b0011 << lane;
      v = (rd >> (8 * lane)) & 32'hFFFF;
      if (sg && v[15]) v = v | 32'hFFFF_0000;
      if (wr) e.wd = {2{wd[15:0]}}; else e.rd = v;
    end else begin
      e.be = 4'hF;
      if (wr) e.wd = wd; else e.rd = rd;
    end
    return e;
  endfunction

  task automatic drive(bit wr, logic [1:0] sz, bit sg, logic [1:0] off,
                       logic [31:0] wd, logic [31:0] rd, bit ml, bit md, string tag);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_size = sz; req_signed = sg;
    req_byte_off = off; req_wdata = wd; mem_rdata = rd;
    mode_load = ml; mode_din = md;
    sb.push_back(model(wr, sz, sg, off, wd, rd, model_big, tag));
    if (ml) model_big = md;
  endtask

  task automatic rd_acc(logic [1:0] sz, bit sg, logic [1:0] off, logic [31:0] rd, string tag);
    drive(1'b0, sz, sg, off, 32'h0, rd, 1'b0, 1'b0, tag);
  endtask

  task automatic wr_acc(logic [1:0] sz, logic [1:0] off, logic [31:0] wd, string tag);
    drive(1'b1, sz, 1'b0, off, wd, 32'h0, 1'b0, 1'b0, tag);
  endtask

  task automatic idle();
    @(negedge clk);
    req_valid = 1'b0; mode_load = 1'b0;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  // monitor
  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      checks++;
      if (sb.size() == 0) begin
        fails++;
        $display("FAIL R10 unexpected response: actual valid=1 expected valid=0");
      end else begin
        exp_t e;
        e = sb.pop_front();
        if (rsp_be !== e.be || rsp_wdata !== e.wd || rsp_rdata !== e.rd || rsp_misalign !== e.mis) begin
          fails++;
          $display("FAIL %s: actual be=%h wd=%h rd=%h mis=%b expected be=%h wd=%h rd=%h mis=%b",
                   e.tag, rsp_be, rsp_wdata, rsp_rdata, rsp_misalign, e.be, e.wd, e.rd, e.mis);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual run still busy, expected finished");
      summary();
      $finish;
    end
  end

  localparam logic [31:0] W = 32'hBBCC_DDEE;

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    // R8 reset state
    checks++;
    if (big_endian !== 1'b0 || rsp_valid !== 1'b0 || rsp_be !== 4'h0 || rsp_rdata !== 32'h0) begin
      fails++;
      $display("FAIL R8 reset: actual mode=%b valid=%b be=%h rd=%h expected 0 0 0 0",
               big_endian, rsp_valid, rsp_be, rsp_rdata);
    end
    // little-endian
    rd_acc(2'd2, 1'b0, 2'd0, W, "R1 LE word read");
    wr_acc(2'd2, 2'd0, 32'h1122_3344, "R1 LE word write");
    for (int k = 0; k < 4; k++) rd_acc(2'd0, 1'b0, 2'(k), W, "R2 LE byte read");
    rd_acc(2'd0, 1'b1, 2'd3, W, "R5 LE signed byte");
    rd_acc(2'd1, 1'b0, 2'd0, W, "R4 LE half off0");
    rd_acc(2'd1, 1'b0, 2'd2, W, "R4 LE half off2");
    rd_acc(2'd1, 1'b1, 2'd2, W, "R5 LE signed half");
    rd_acc(2'd0, 1'b1, 2'd1, 32'h0000_7F00, "R5 signed byte positive");
    wr_acc(2'd0, 2'd1, 32'h0000_005A, "R6 LE byte write");
    wr_acc(2'd1, 2'd2, 32'h0000_BEEF, "R6 LE half write");
    rd_acc(2'd1, 1'b0, 2'd1, W, "R7 half misaligned");
    wr_acc(2'd2, 2'd2, 32'hCAFE_F00D, "R7 word misaligned");
    rd_acc(2'd3, 1'b0, 2'd0, W, "R7 reserved size");
    // R9 mode write with a load in the same cycle: old mode applies
    drive(1'b0, 2'd0, 1'b0, 2'd0, 32'h0, W, 1'b1, 1'b1, "R9 same-cycle load old mode");
    rd_acc(2'd0, 1'b0, 2'd0, W, "R9 next load new mode");
    // big-endian
    for (int k = 1; k < 4; k++) rd_acc(2'd0, 1'b0, 2'(k), W, "R3 BE byte read");
    rd_acc(2'd1, 1'b0, 2'd0, W, "R4 BE half off0");
    rd_acc(2'd1, 1'b0, 2'd2, W, "R4 BE half off2");
    rd_acc(2'd1, 1'b1, 2'd0, 32'h8001_0000, "R5 BE signed half");
    rd_acc(2'd2, 1'b0, 2'd0, W, "R1 BE word read");
    wr_acc(2'd2, 2'd0, 32'h1122_3344, "R1 BE word write");
    wr_acc(2'd0, 2'd0, 32'h0000_00A5, "R3 BE byte write");
    wr_acc(2'd1, 2'd0, 32'h0000_1234, "R6 BE half write");
    wr_acc(2'd1, 2'd3, 32'h0000_1234, "R7 BE half misaligned");
    drive(1'b0, 2'd0, 1'b0, 2'd3, 32'h0, W, 1'b1, 1'b0, "R9 back to LE same cycle");
    rd_acc(2'd0, 1'b0, 2'd3, W, "R9 LE after switch");
    idle();
    idle();
    // R10 idle outputs
    checks++;
    if (rsp_valid !== 1'b0 || rsp_be !== 4'h0 || rsp_misalign !== 1'b0 || sb.size() != 0) begin
      fails++;
      $display("FAIL R10 idle: actual valid=%b be=%h mis=%b pending=%0d expected 0 0 0 0",
               rsp_valid, rsp_be, rsp_misalign, sb.size());
    end
    done = 1'b1;
    summary();
    $finish;
  end
endmodule